// File: doc/BRIEF.md
# Timer Software Event and Flag Unit

This block sits next to a 16-bit general-purpose timer and gathers everything about its event requests and sticky status flags. Software reaches it through a plain write strobe with an address and data, and through a combinational read port. A write to the software-event register produces single-cycle request pulses toward the timer. The four requestable events are overflow, channel 1, commutation and break. A software overflow request appears as a counter reload request.

Each event also has a sticky status flag. A flag is set by its hardware source from the timer or by the matching software request. The overflow flag is special: the software request and the trigger-driven counter reinitialisation set it only when both the overflow-disable and overflow-source configuration inputs are low. Software clears a flag by writing 0 to its bit. A registered interrupt output is raised whenever an enabled flag is set.

Top module: `tmr_event_unit`

## Requirements
- R1: After reset, the flag register and the enable register both read 0, and irq, reloadReq, ch1Evt, comEvt and brkEvt are all 0.
- R2: A write to address 2 (software events) acts on each data bit set to 1. Bit 0 gives reloadReq, bit 1 gives ch1Evt, bit 5 gives a commutation pulse and bit 7 gives brkEvt. The pulse is high in exactly the one cycle that follows the write edge. Bits written as 0 produce no pulse.
- R3: Address 2 always reads 0. In the flag register (address 0) and the enable register (address 1), only bits 0, 1, 5 and 7 can read as 1. Address 3 reads 0, and writes to it change nothing.
- R4: A commutation request pulses comEvt only on the channels marked in the complementary-channel mask (default 2'b01). The other channels stay 0.
- R5: The overflow flag (bit 0) is always set by hwOvf. It is set by a software overflow request or by trigReinit only when ovfDisable and ovfSource are both 0. The reloadReq pulse does not depend on these two inputs.
- R6: A write to address 0 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R7: If a set source and a software clear hit the same flag in the same cycle, the flag ends up set.
- R8: irq is a register. In each cycle it equals the OR over all events of flag AND enable, as they stood one cycle earlier.
- R9: The channel 1, commutation and break flags (bits 1, 5, 7) are set by their hardware inputs or by the matching software request. Hardware commutation produces no comEvt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address (0 flags, 1 enables, 2 software events) |
| wrData | input | DATA_W | Write data |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Combinational read data |
| hwOvf | input | 1 | Hardware overflow event from the counter |
| hwCh1 | input | 1 | Hardware channel 1 event |
| hwCom | input | 1 | Hardware commutation event |
| hwBrk | input | 1 | Hardware break event |
| trigReinit | input | 1 | Counter reinitialised by a trigger |
| ovfDisable | input | 1 | Overflow event disable configuration |
| ovfSource | input | 1 | Overflow source restriction configuration |
| reloadReq | output | 1 | One-cycle counter reload request |
| ch1Evt | output | 1 | One-cycle software channel 1 event |
| comEvt | output | NUM_CH | One-cycle commutation pulse per complementary channel |
| brkEvt | output | 1 | One-cycle software break event |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions take for granted that wrEn, wrAddr, wrData and the hardware event inputs are steady around the rising clock edge. They also assume that these inputs are low while reset is held, so no strobe is decoded before the first edge after reset. The stimulus changes every input only on falling edges and keeps all strobes low during reset. A hardware event and a register write may still share a cycle, and the set-over-clear checks depend on that case. The bench lines up the overflow-configuration inputs before each overflow-related request, a cycle ahead of the write.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;

  // event index order inside the unit: 0 overflow, 1 channel 1, 2 commutation, 3 break
  localparam int unsigned EVT_N   = 4;
  localparam int unsigned EV_OVF  = 0;
  localparam int unsigned EV_CH1  = 1;
  localparam int unsigned EV_COM  = 2;
  localparam int unsigned EV_BRK  = 3;

  typedef enum logic [1:0] {
    ADDR_FLAG = 2'd0,
    ADDR_IEN  = 2'd1,
    ADDR_SWEV = 2'd2,
    ADDR_NONE = 2'd3
  } regAddr_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic             flagWr;
    logic             ienWr;
    logic [EVT_N-1:0] swReq;
    logic [EVT_N-1:0] wrBits;
    logic             rdFlag;
    logic             rdIen;
  } ctlStb_t;

  // register bit position of each event
  function automatic int unsigned evtBit(input int unsigned idx);
    case (idx)
      EV_OVF:  return 0;
      EV_CH1:  return 1;
      EV_COM:  return 5;
      default: return 7;
    endcase
  endfunction

endpackage

// File: rtl/tmr_evt_ctrl.sv
module tmr_evt_ctrl
  import tmr_evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctlStb_t           stb
);

  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(ADDR_FLAG);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(ADDR_IEN);
  localparam logic [ADDR_W-1:0] A_SWEV = ADDR_W'(ADDR_SWEV);

  logic hitFlag;
  logic hitIen;
  logic hitSwev;
  logic [EVT_N-1:0] dataBits;
  logic unusedData;

  assign hitFlag = wrEn && (wrAddr == A_FLAG);
  assign hitIen  = wrEn && (wrAddr == A_IEN);
  assign hitSwev = wrEn && (wrAddr == A_SWEV);

  always_comb begin
    for (int unsigned i = 0; i < EVT_N; i++) begin
      dataBits[i] = wrData[evtBit(i)];
    end
  end

  assign unusedData = ^wrData;

  always_comb begin
    stb        = '0;
    stb.flagWr = hitFlag;
    stb.ienWr  = hitIen;
    stb.wrBits = dataBits;
    stb.swReq  = hitSwev ? dataBits : '0;
    stb.rdFlag = (rdAddr == A_FLAG);
    stb.rdIen  = (rdAddr == A_IEN);
  end

endmodule

// File: rtl/tmr_evt_flag.sv
module tmr_evt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic setIn,
  input  logic clrIn,
  input  logic enWr,
  input  logic enIn,
  output logic flag,
  output logic enable
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      enable <= 1'b0;
    end else begin
      if (setIn)      flag <= 1'b1;
      else if (clrIn) flag <= 1'b0;
      if (enWr)       enable <= enIn;
    end
  end

endmodule

// File: rtl/tmr_evt_dp.sv
module tmr_evt_dp
  import tmr_evt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_CH = 2,
  parameter logic [NUM_CH-1:0] COMP_MASK = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStb_t           stb,
  input  logic [EVT_N-1:0]  hwEvt,
  input  logic              trigReinit,
  input  logic              ovfDisable,
  input  logic              ovfSource,
  output logic [DATA_W-1:0] rdData,
  output logic              reloadReq,
  output logic              ch1Evt,
  output logic [NUM_CH-1:0] comEvt,
  output logic              brkEvt,
  output logic              irq
);

  logic [EVT_N-1:0] setVec;
  logic [EVT_N-1:0] clrVec;
  logic [EVT_N-1:0] flags;
  logic [EVT_N-1:0] ens;
  logic             swOvfAllowed;

  assign swOvfAllowed = !ovfDisable && !ovfSource;

  always_comb begin
    for (int unsigned i = 0; i < EVT_N; i++) begin
      setVec[i] = hwEvt[i] | stb.swReq[i];
      clrVec[i] = stb.flagWr & ~stb.wrBits[i];
    end
    setVec[EV_OVF] = hwEvt[EV_OVF] |
                     (swOvfAllowed & (stb.swReq[EV_OVF] | trigReinit));
  end

  for (genvar g = 0; g < EVT_N; g++) begin : gFlag
    tmr_evt_flag uCell (
      .clk    (clk),
      .rst_n  (rst_n),
      .setIn  (setVec[g]),
      .clrIn  (clrVec[g]),
      .enWr   (stb.ienWr),
      .enIn   (stb.wrBits[g]),
      .flag   (flags[g]),
      .enable (ens[g])
    );

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      setVec[g] |=> flags[g]);

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clrVec[g] && !setVec[g]) |=> !flags[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reloadReq <= 1'b0;
      ch1Evt    <= 1'b0;
      comEvt    <= '0;
      brkEvt    <= 1'b0;
      irq       <= 1'b0;
    end else begin
      reloadReq <= stb.swReq[EV_OVF];
      ch1Evt    <= stb.swReq[EV_CH1];
      comEvt    <= {NUM_CH{stb.swReq[EV_COM]}} & COMP_MASK;
      brkEvt    <= stb.swReq[EV_BRK];
      irq       <= |(flags & ens);
    end
  end

  always_comb begin
    rdData = '0;
    for (int unsigned i = 0; i < EVT_N; i++) begin
      if (stb.rdFlag) rdData[evtBit(i)] = flags[i];
      if (stb.rdIen)  rdData[evtBit(i)] = ens[i];
    end
  end

  // R2
  reload_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reloadReq |-> $past(stb.swReq[EV_OVF]));

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((flags & ens) != '0));

  // R5
  ovf_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hwEvt[EV_OVF] && (ovfDisable || ovfSource) && !flags[EV_OVF]) |=> !flags[EV_OVF]);

endmodule

// File: rtl/tmr_event_unit.sv
module tmr_event_unit
  import tmr_evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_CH = 2,
  parameter logic [NUM_CH-1:0] COMP_MASK = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              hwOvf,
  input  logic              hwCh1,
  input  logic              hwCom,
  input  logic              hwBrk,
  input  logic              trigReinit,
  input  logic              ovfDisable,
  input  logic              ovfSource,
  output logic              reloadReq,
  output logic              ch1Evt,
  output logic [NUM_CH-1:0] comEvt,
  output logic              brkEvt,
  output logic              irq
);

  ctlStb_t stb;
  logic [EVT_N-1:0] hwEvt;

  assign hwEvt = {hwBrk, hwCom, hwCh1, hwOvf};

  tmr_evt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .stb    (stb)
  );

  tmr_evt_dp #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .COMP_MASK(COMP_MASK)) uDp (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .hwEvt      (hwEvt),
    .trigReinit (trigReinit),
    .ovfDisable (ovfDisable),
    .ovfSource  (ovfSource),
    .rdData     (rdData),
    .reloadReq  (reloadReq),
    .ch1Evt     (ch1Evt),
    .comEvt     (comEvt),
    .brkEvt     (brkEvt),
    .irq        (irq)
  );

endmodule

// File: tb/tb_tmr_event_unit.sv
`timescale 1ns/10ps
module tb_tmr_event_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [15:0] rdData;
  logic hwOvf = 1'b0, hwCh1 = 1'b0, hwCom = 1'b0, hwBrk = 1'b0;
  logic trigReinit = 1'b0, ovfDisable = 1'b0, ovfSource = 1'b0;
  logic reloadReq, ch1Evt, brkEvt, irq;
  logic [1:0] comEvt;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // ctl layout: {irq, brkEvt, comEvt[1:0], ch1Evt, reloadReq}
  typedef struct {
    string       tag;
    logic [1:0]  ra;
    logic [15:0] rd;
    logic [5:0]  ctl;
  } item_t;

  item_t sbQ[$];

  always #2 clk = ~clk;

  tmr_event_unit dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .hwOvf(hwOvf), .hwCh1(hwCh1),
    .hwCom(hwCom), .hwBrk(hwBrk), .trigReinit(trigReinit),
    .ovfDisable(ovfDisable), .ovfSource(ovfSource), .reloadReq(reloadReq),
    .ch1Evt(ch1Evt), .comEvt(comEvt), .brkEvt(brkEvt), .irq(irq)
  );

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      item_t it;
      wait (sbQ.size() != 0);
      #0.2;
      it = sbQ.pop_front();
      rdAddr = it.ra;
      #0.1;
      checks++;
      if (rdData !== it.rd || {irq, brkEvt, comEvt, ch1Evt, reloadReq} !== it.ctl) begin
        fails++;
        $display("FAIL %s: rd=%h ctl=%b expected rd=%h ctl=%b", it.tag, rdData,
                 {irq, brkEvt, comEvt, ch1Evt, reloadReq}, it.rd, it.ctl);
      end
    end
  end

  initial begin
    #80000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      report();
    end
  end

  task automatic expectItem(input string tag, input logic [1:0] ra,
                            input logic [15:0] rd, input logic [5:0] ctl);
    item_t it;
    it.tag = tag; it.ra = ra; it.rd = rd; it.ctl = ctl;
    sbQ.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    expectItem("R1 flags after reset", 2'd0, 16'h0000, 6'b000000);
    expectItem("R1 enables after reset", 2'd1, 16'h0000, 6'b000000);

    busWrite(2'd1, 16'hFFFF);
    expectItem("R3 enable reserved bits", 2'd1, 16'h00A3, 6'b000000);

    busWrite(2'd2, 16'h0002);
    expectItem("R2 ch1 pulse", 2'd0, 16'h0002, 6'b000010);
    tick();
    expectItem("R8 irq one cycle later", 2'd0, 16'h0002, 6'b100000);
    expectItem("R3 event reg reads zero", 2'd2, 16'h0000, 6'b100000);

    busWrite(2'd0, 16'h00FD);
    expectItem("R6 clear ch1 flag", 2'd0, 16'h0000, 6'b100000);
    tick();
    expectItem("R8 irq drops", 2'd0, 16'h0000, 6'b000000);

    busWrite(2'd1, 16'h0000);
    busWrite(2'd2, 16'h0000);
    expectItem("R2 zero write no effect", 2'd0, 16'h0000, 6'b000000);

    busWrite(2'd2, 16'h0020);
    expectItem("R4 commutation masked", 2'd0, 16'h0020, 6'b000100);
    tick();
    expectItem("R2 pulse one cycle", 2'd0, 16'h0020, 6'b000000);

    busWrite(2'd2, 16'h0080);
    expectItem("R9 break request", 2'd0, 16'h00A0, 6'b010000);

    busWrite(2'd2, 16'h0001);
    expectItem("R5 sw overflow allowed", 2'd0, 16'h00A1, 6'b000001);
    tick();
    expectItem("R2 reload one cycle", 2'd0, 16'h00A1, 6'b000000);

    busWrite(2'd0, 16'h00FE);
    expectItem("R6 ones keep flags", 2'd0, 16'h00A0, 6'b000000);
    busWrite(2'd0, 16'h0000);
    expectItem("R6 clear all", 2'd0, 16'h0000, 6'b000000);

    ovfSource = 1'b1;
    tick();
    busWrite(2'd2, 16'h0001);
    expectItem("R5 source blocks sw flag", 2'd0, 16'h0000, 6'b000001);
    ovfSource = 1'b0; ovfDisable = 1'b1; trigReinit = 1'b1;
    tick();
    trigReinit = 1'b0;
    expectItem("R5 disable blocks reinit", 2'd0, 16'h0000, 6'b000000);
    hwOvf = 1'b1;
    tick();
    hwOvf = 1'b0;
    expectItem("R5 hw overflow sets", 2'd0, 16'h0001, 6'b000000);
    ovfDisable = 1'b0;
    busWrite(2'd0, 16'h0000);
    trigReinit = 1'b1;
    tick();
    trigReinit = 1'b0;
    expectItem("R5 reinit sets flag", 2'd0, 16'h0001, 6'b000000);

    hwCh1 = 1'b1;
    busWrite(2'd0, 16'h0000);
    hwCh1 = 1'b0;
    expectItem("R7 set beats clear", 2'd0, 16'h0002, 6'b000000);

    busWrite(2'd1, 16'h0002);
    expectItem("R8 irq waits a cycle", 2'd1, 16'h0002, 6'b000000);
    tick();
    expectItem("R8 irq raised", 2'd0, 16'h0002, 6'b100000);
    busWrite(2'd0, 16'h0000);
    expectItem("R8 irq held from old flag", 2'd0, 16'h0000, 6'b100000);
    tick();
    expectItem("R8 irq cleared", 2'd0, 16'h0000, 6'b000000);

    hwCom = 1'b1; hwBrk = 1'b1;
    tick();
    hwCom = 1'b0; hwBrk = 1'b0;
    expectItem("R9 hw com and break flags", 2'd0, 16'h00A0, 6'b000000);

    busWrite(2'd3, 16'hFFFF);
    expectItem("R3 addr3 reads zero", 2'd3, 16'h0000, 6'b000000);
    expectItem("R3 addr3 write left flags", 2'd0, 16'h00A0, 6'b000000);
    expectItem("R3 addr3 write left enables", 2'd1, 16'h0002, 6'b000000);

    wait (sbQ.size() == 0);
    #1;
    finished = 1;
    report();
  end

endmodule